// File: doc/BRIEF.md
# Reversible-Cell Ripple Adder-Subtractor

This block adds or subtracts two unsigned N-bit operands using nothing but a cascade of four-in, four-out reversible cells, one cell per bit. Every cell is its own instance of one fixed gate equation. A single mode line picks the operation, with 0 for addition and 1 for subtraction. In subtract mode a real borrow travels up the chain from cell to cell. B is never inverted and no carry is injected to form a two's complement.

Each cell has a control input (the mode), the two operand bits, and the incoming carry or borrow. From these it forms four values: the result bit, the outgoing carry or borrow, and two leftover values that no other cell uses. The leftover values of all cells are brought out as one garbage vector. The only link between neighbouring cells is the carry or borrow output of one feeding the fourth input of the next. The block is purely combinational.

The parameter `FIRST_CIN_FROM_MODE` chooses what the lowest cell receives as its incoming carry or borrow. When it is set (the default), the lowest cell takes the mode line, so subtraction gives A − B − 1. When it is cleared, the lowest cell takes 0, so subtraction gives a plain A − B. Addition is A + B with either setting. The cost figure of the chain, six units per cell, is kept as the localparam `QUANTUM_COST`.

Top module: `addsub_rev`

## Requirements
- R1: With mode = 0, {carry_borrow, result} equals a + b as an (N+1)-bit unsigned sum, for either setting of FIRST_CIN_FROM_MODE. This includes the wrap case 255 + 1 = 0 with carry 1 when N = 8.
- R2: With mode = 1 and FIRST_CIN_FROM_MODE = 1, result equals (a − b − 1) mod 2^N, and carry_borrow is 1 exactly when a < b + 1. For example, 0 − 0 gives 2^N − 1 with borrow 1.
- R3: With mode = 1 and FIRST_CIN_FROM_MODE = 0, result equals (a − b) mod 2^N, and carry_borrow is 1 exactly when a < b. For example, 5 − 7 gives 254 with borrow 1 at N = 8, and 0 − 0 gives 0 with borrow 0.
- R4: The garbage vector is 2N bits wide, and bit 2i holds the first leftover value of cell i. That value always equals a[i].
- R5: Garbage bit 2i+1 holds the second leftover value of cell i. It equals b[i] when mode = 0. When mode = 1 it equals the inverse of the borrow entering cell i. That incoming borrow is 1 exactly when a mod 2^i < b mod 2^i + c0, where c0 is the lowest cell's incoming value (1 if FIRST_CIN_FROM_MODE = 1, else 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 1 | 0 selects add, 1 selects subtract |
| a | input | N | Unsigned operand A (minuend in subtract mode) |
| b | input | N | Unsigned operand B (subtrahend in subtract mode) |
| result | output | N | Sum or difference |
| carry_borrow | output | 1 | Carry out in add mode, borrow out in subtract mode |
| garbage | output | 2N | Leftover cell outputs, bit 2i and bit 2i+1 from cell i |

## Verification
The result bits and the carry/borrow flag are produced in the same evaluation, and so are the garbage bits. So for every applied operand pair, the bench checks the arithmetic outcome and the garbage values of every cell together. This matters most in subtract mode, where the second garbage bit of each cell shows the borrow that cell received. The bench sweeps every operand pair at N = 8 in both modes. At the same time it drives one random pair each cycle into a 16-bit copy, and feeds the same 8-bit pairs to a copy whose lowest incoming value is tied to 0. The wrap cases (all-ones plus one, zero minus zero, smaller minus larger) are listed first, and each result is judged against an integer model.

// File: rtl/addsub_rev_pkg.sv
// Package: constants shared by the reversible adder-subtractor.
// Assumes each cell is the same four-in, four-out gate with two unused outputs.
package addsub_rev_pkg;
    localparam int CELL_QCOST   = 6;
    localparam int CELL_GARBAGE = 2;

    // Cost figure of a chain of n cells.
    function automatic int chain_qcost(input int n);
        return n * CELL_QCOST;
    endfunction
endpackage

// File: rtl/rev_cell.sv
// Module: rev_cell
// One four-in, four-out reversible gate.
//   o0 = i1
//   o1 = (~i0 & i2) ^ (i0 & ~i3)
//   o2 = ((i0 ^ i1) & (i2 ^ i3)) ^ (i2 & i3)
//   o3 = i1 ^ i2 ^ i3
// Assumes nothing about its inputs; purely combinational.
module rev_cell (
    input  logic i0,
    input  logic i1,
    input  logic i2,
    input  logic i3,
    output logic o0,
    output logic o1,
    output logic o2,
    output logic o3
);
    // Gate equations.
    always_comb begin
        o0 = i1;
        o1 = (~i0 & i2) ^ (i0 & ~i3);
        o2 = ((i0 ^ i1) & (i2 ^ i3)) ^ (i2 & i3);
        o3 = i1 ^ i2 ^ i3;
    end
endmodule

// File: rtl/rev_chain.sv
// Module: rev_chain
// Cascades N rev_cell instances. Cell i gets (mode, a[i], b[i], link[i]).
// link[i+1] is the third output of cell i, and link[0] is either mode or 0,
// chosen by FIRST_CIN_FROM_MODE. The first two outputs of each cell go to the
// garbage vector. Assumes N >= 1.
module rev_chain #(
    parameter int N                   = 8,
    parameter bit FIRST_CIN_FROM_MODE = 1'b1
) (
    input  logic             mode,
    input  logic [N-1:0]     a,
    input  logic [N-1:0]     b,
    output logic [N-1:0]     sum,
    output logic             last_r,
    output logic [2*N-1:0]   garbage
);
    logic [N:0] link;

    // Choose the lowest cell's incoming carry/borrow.
    if (FIRST_CIN_FROM_MODE) begin : g_cin_mode
        assign link[0] = mode;
    end else begin : g_cin_zero
        assign link[0] = 1'b0;
    end

    // One reversible cell per bit; the third output ripples up.
    for (genvar i = 0; i < N; i++) begin : g_cell
        rev_cell u_cell (
            .i0 (mode),
            .i1 (a[i]),
            .i2 (b[i]),
            .i3 (link[i]),
            .o0 (garbage[2*i]),
            .o1 (garbage[2*i+1]),
            .o2 (link[i+1]),
            .o3 (sum[i])
        );
    end

    assign last_r = link[N];
endmodule

// File: rtl/addsub_rev.sv
// Module: addsub_rev (top)
// N-bit ripple adder-subtractor made only of reversible cells.
// mode = 0 adds, mode = 1 subtracts with a true borrow chain.
// Purely combinational; it has no clock and no reset.
module addsub_rev
    import addsub_rev_pkg::*;
#(
    parameter int N                   = 8,
    parameter bit FIRST_CIN_FROM_MODE = 1'b1
) (
    input  logic             mode,
    input  logic [N-1:0]     a,
    input  logic [N-1:0]     b,
    output logic [N-1:0]     result,
    output logic             carry_borrow,
    output logic [2*N-1:0]   garbage
);
    localparam int QUANTUM_COST = chain_qcost(N);
    localparam int GARBAGE_W    = N * CELL_GARBAGE;

    logic [GARBAGE_W-1:0] garb_w;

    // Cell cascade.
    rev_chain #(
        .N                   (N),
        .FIRST_CIN_FROM_MODE (FIRST_CIN_FROM_MODE)
    ) u_chain (
        .mode    (mode),
        .a       (a),
        .b       (b),
        .sum     (result),
        .last_r  (carry_borrow),
        .garbage (garb_w)
    );

    assign garbage = garb_w;
endmodule

// File: rtl/addsub_rev_chk.sv
// Module: addsub_rev_chk
// Checker bound to addsub_rev. It relates the arithmetic outputs and the
// garbage vector to the operands. Assertions are immediate and are evaluated
// when the combinational inputs change. They are skipped while inputs are unknown.
module addsub_rev_chk
    import addsub_rev_pkg::*;
#(
    parameter int N                   = 8,
    parameter bit FIRST_CIN_FROM_MODE = 1'b1,
    parameter int QCOST               = 48
) (
    input logic             mode,
    input logic [N-1:0]     a,
    input logic [N-1:0]     b,
    input logic [N-1:0]     result,
    input logic             carry_borrow,
    input logic [2*N-1:0]   garbage
);
    // Elaboration sanity on the reported cost figure.
    if (QCOST != CELL_QCOST * N) begin : g_bad_cost
        $error("quantum cost localparam mismatch");
    end

    logic [N:0]   wide_sum;
    logic [N:0]   wide_diff;
    logic [N-1:0] p_bits;
    logic [N-1:0] q_bits;
    logic         c0;

    // Reference arithmetic and garbage split.
    always_comb begin
        c0        = FIRST_CIN_FROM_MODE ? mode : 1'b0;
        wide_sum  = {1'b0, a} + {1'b0, b};
        wide_diff = {1'b0, a} - {1'b0, b} - {{N{1'b0}}, c0};
        for (int i = 0; i < N; i++) begin
            p_bits[i] = garbage[2*i];
            q_bits[i] = garbage[2*i+1];
        end
    end

    // Checks.
    always_comb begin
        if (!$isunknown({mode, a, b})) begin
            if (!mode) begin
                AST_ADD_SUM: assert ({carry_borrow, result} == wide_sum); // R1
                AST_Q_ADD: assert (q_bits == b); // R5
            end else begin
                if (FIRST_CIN_FROM_MODE) begin
                    AST_SUB_MINUS_ONE: assert ({carry_borrow, result} == wide_diff); // R2
                end else begin
                    AST_SUB_PLAIN: assert ({carry_borrow, result} == wide_diff); // R3
                end
                AST_Q_BORROW: assert (~q_bits == (a ^ b ^ result)); // R5
            end
            AST_P_COPY: assert (p_bits == a); // R4
        end
    end
endmodule

bind addsub_rev addsub_rev_chk #(
    .N                   (N),
    .FIRST_CIN_FROM_MODE (FIRST_CIN_FROM_MODE),
    .QCOST               (QUANTUM_COST)
) u_chk (
    .mode         (mode),
    .a            (a),
    .b            (b),
    .result       (result),
    .carry_borrow (carry_borrow),
    .garbage      (garbage)
);

// File: tb/sim_addsub_rev.sv
// Scoreboard bench: a driver task applies operands on the falling edge and
// queues expected values; a monitor pops and compares on the rising edge.
module sim_addsub_rev;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        mode = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] a16 = '0, b16 = '0;

    logic [7:0]  r8, r8z;
    logic        c8, c8z;
    logic [15:0] g8, g8z;
    logic [15:0] r16;
    logic        c16;
    logic [31:0] g16;

    addsub_rev #(.N(8), .FIRST_CIN_FROM_MODE(1'b1)) u0 (
        .mode(mode), .a(a8), .b(b8), .result(r8), .carry_borrow(c8), .garbage(g8));
    addsub_rev #(.N(16), .FIRST_CIN_FROM_MODE(1'b1)) u1 (
        .mode(mode), .a(a16), .b(b16), .result(r16), .carry_borrow(c16), .garbage(g16));
    addsub_rev #(.N(8), .FIRST_CIN_FROM_MODE(1'b0)) u2 (
        .mode(mode), .a(a8), .b(b8), .result(r8z), .carry_borrow(c8z), .garbage(g8z));

    typedef struct {
        bit          m;
        logic [7:0]  r8;  logic c8;  logic [15:0] g8;
        logic [7:0]  r8z; logic c8z; logic [15:0] g8z;
        logic [15:0] r16; logic c16; logic [31:0] g16;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // Compare one value and log a failure.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Integer model of result and carry/borrow.
    function automatic logic [16:0] model(input int n, input int a, input int b,
                                          input bit m, input bit c0);
        int v;
        int mask;
        logic [16:0] o;
        mask = (1 << n) - 1;
        if (!m) begin
            v = a + b;
            o = '0;
            o[15:0] = 16'(v & mask);
            o[16]   = ((v >> n) & 1) != 0;
        end else begin
            v = a - b - int'(c0);
            o = '0;
            o[15:0] = 16'(v & mask);
            o[16]   = (v < 0);
        end
        return o;
    endfunction

    // Integer model of the garbage vector.
    function automatic logic [31:0] gmodel(input int n, input int a, input int b,
                                           input bit m, input bit c0);
        logic [31:0] g;
        int lo;
        g = '0;
        for (int i = 0; i < n; i++) begin
            lo = (1 << i) - 1;
            g[2*i] = ((a >> i) & 1) != 0;
            if (!m) g[2*i+1] = ((b >> i) & 1) != 0;
            else    g[2*i+1] = !((a & lo) < ((b & lo) + int'(c0)));
        end
        return g;
    endfunction

    // Driver: apply one 8-bit pair plus a random 16-bit pair, queue expectations.
    task automatic drive(input bit m, input int a, input int b);
        exp_t e;
        logic [16:0] o;
        int ra, rb;
        @(negedge clk);
        ra = int'($urandom & 32'hFFFF);
        rb = int'($urandom & 32'hFFFF);
        mode = m; a8 = 8'(a); b8 = 8'(b); a16 = 16'(ra); b16 = 16'(rb);
        e.m = m;
        o = model(8, a, b, m, m);     e.r8  = o[7:0];  e.c8  = o[16];
        e.g8  = 16'(gmodel(8, a, b, m, m));
        o = model(8, a, b, m, 1'b0);  e.r8z = o[7:0];  e.c8z = o[16];
        e.g8z = 16'(gmodel(8, a, b, m, 1'b0));
        o = model(16, ra, rb, m, m);  e.r16 = o[15:0]; e.c16 = o[16];
        e.g16 = gmodel(16, ra, rb, m, m);
        exp_q.push_back(e);
    endtask

    // Monitor: pop one expectation per rising edge and compare.
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (!e.m) begin
                chk("R1 u0 result", 32'(r8), 32'(e.r8));
                chk("R1 u0 carry",  32'(c8), 32'(e.c8));
                chk("R1 u2 result", 32'(r8z), 32'(e.r8z));
                chk("R1 u2 carry",  32'(c8z), 32'(e.c8z));
                chk("R1 u1 result", 32'(r16), 32'(e.r16));
                chk("R1 u1 carry",  32'(c16), 32'(e.c16));
            end else begin
                chk("R2 u0 result", 32'(r8), 32'(e.r8));
                chk("R2 u0 borrow", 32'(c8), 32'(e.c8));
                chk("R3 u2 result", 32'(r8z), 32'(e.r8z));
                chk("R3 u2 borrow", 32'(c8z), 32'(e.c8z));
                chk("R2 u1 result", 32'(r16), 32'(e.r16));
                chk("R2 u1 borrow", 32'(c16), 32'(e.c16));
            end
            chk("R4 u0 garbage", 32'(g8 & 16'h5555), 32'(e.g8 & 16'h5555));
            chk("R4 u1 garbage", g16 & 32'h55555555, e.g16 & 32'h55555555);
            chk("R5 u0 garbage", 32'(g8 & 16'hAAAA), 32'(e.g8 & 16'hAAAA));
            chk("R5 u2 garbage", 32'(g8z & 16'hAAAA), 32'(e.g8z & 16'hAAAA));
            chk("R5 u1 garbage", g16 & 32'hAAAAAAAA, e.g16 & 32'hAAAAAAAA);
        end
    end

    // Stimulus: reset-state pattern, wrap corners, then the full 8-bit sweep.
    initial begin
        drive(1'b0, 0, 0);            // zero operands, add mode (R1, R4, R5)
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(1'b0, 255, 1);          // R1 wrap to 0 with carry
        drive(1'b0, 255, 255);        // R1 maximum sum
        drive(1'b1, 0, 0);            // R2 gives 255 with borrow; R3 gives 0
        drive(1'b1, 5, 7);            // R3 underflow to 254
        drive(1'b1, 7, 5);            // R2 gives 1, R3 gives 2
        for (int m = 0; m < 2; m++)
            for (int x = 0; x < 256; x++)
                for (int y = 0; y < 256; y++)
                    drive(bit'(m), x, y);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule